// File: doc/BRIEF.md
# Configuration Header Register File

This block holds a 256-byte device configuration header and serves register-style reads and writes of one to four bytes at any byte offset. A request carries a write flag, a byte offset, a length and up to four little-endian data bytes. Every request gets exactly one response, one clock after it is accepted. A response carries the read data (zero for writes and rejected requests) and an error flag.

Writes into the first 64 bytes pass through a fixed per-byte writable-bit mask, so read-only bits keep their old value. The upper status byte clears bits on writes of one. The expansion ROM base register zeroes itself when it is sized with all ones. Bytes above the header are stored exactly as written. Reset reloads a default image and then forces the header into a quiet state. A one-cycle event output reports every change of the memory-enable bit.

The request and response channels are valid/ready. The request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or when the waiting response is being taken in that same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady and no new request is accepted.

Top module: `cfgs_regfile`

## Requirements
- R1: An access with length 0, length greater than 4, or offset plus length greater than 256 is rejected. The response then has `rsp_err`=1 and `rsp_rdata`=0, and no stored byte changes.
- R2: A read returns the byte at offset+i on data bits [8i+7:8i] for each i below the length. Unused lanes read 0. The response appears in the cycle after acceptance, and a write response carries `rsp_rdata`=0.
- R3: For a byte at address a below 64, a write stores (old AND NOT mask) OR (data AND mask). The mask is 0xFF at 0x04, 0x0C, 0x3C and 0x10 to 0x27, 0x07 at 0x05, 0xF9 at 0x07, and 0x01, 0xF8, 0xFF, 0xFF at 0x30 to 0x33. It is 0x00 everywhere else, including 0x06.
- R4: At offset 0x07, each writable bit written as 1 clears the stored bit, and each bit written as 0 is kept.
- R5: Bytes at offsets 64 to 255 store the full data byte with no mask.
- R6: A 4-byte write at offset 0x30 with data bits 31:11 all ones sets bytes 0x30 to 0x33 to zero. Any other write to those bytes follows R3.
- R7: A write at offset 0x04 longer than 2 bytes is rejected as in R1. A write whose offset falls in 0x10 to 0x27 or 0x30 to 0x33 and is not a multiple of 4 is also rejected as in R1.
- R8: After reset, byte k reads (k XOR 0x5A), with three exceptions. Bits 2:0 of byte 0x04 are cleared. Bytes 0x14 to 0x17, 0x1C to 0x27 and 0x30 to 0x33 read 0.
- R9: `mem_evt` is high for exactly one cycle, the cycle after an accepted write that changes bit 1 of byte 0x04. `mem_on` always shows the current value of that bit.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0, the response fields hold steady, and a request offered in that time is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset of the first byte |
| req_len | input | 3 | Number of bytes, 1 to 4 valid |
| req_wdata | input | 32 | Write data, byte i on bits [8i+7:8i] |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | 32 | Read data, little-endian lanes |
| rsp_err | output | 1 | Request was rejected |
| mem_evt | output | 1 | One-cycle pulse when the memory-enable bit changes |
| mem_on | output | 1 | Current memory-enable bit (byte 0x04 bit 1) |

## Verification
The bench targets the places where a plausible design slips:
- The status byte at 0x07 is written with all ones. A design that merges it like any other masked byte would set bits instead of clearing them.
- The ROM register is written with all ones above bit 11 and with a near miss. A design with the wrong threshold would either keep a stale base or wrongly zero it.
- Accesses are pushed across the end of the space, across the command byte with length 3 or more, and onto unaligned base-register offsets. A design that gets any of these wrong would corrupt neighbouring bytes or fail to flag the error.
- A response is stalled while another write is offered. A design that ignores back-pressure would lose the held data or perform the offered write.
- A reset in the middle of the run confirms that the quiet-state clears are applied on top of the reloaded image.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  localparam int HDR_BYTES   = 64;
  localparam int CMD_OFF     = 4;
  localparam int STAT_LO_OFF = 6;
  localparam int STAT_HI_OFF = 7;
  localparam int BASE_LO     = 16;
  localparam int BASE_HI     = 40;
  localparam int ROM_OFF     = 48;
  localparam int ROM_LSB     = 11;
  localparam int MEM_EN_BIT  = 1;
  localparam logic [7:0] CMD_QUIET = 8'h07;

  // writable bits of each header byte
  function automatic logic [7:0] wr_mask(input int a);
    logic [7:0] m;
    case (a)
      CMD_OFF:         m = 8'hFF;
      CMD_OFF + 1:     m = 8'h07;
      STAT_HI_OFF:     m = 8'hF9;
      12:              m = 8'hFF;
      60:              m = 8'hFF;
      ROM_OFF:         m = 8'h01;
      ROM_OFF + 1:     m = 8'hF8;
      ROM_OFF + 2:     m = 8'hFF;
      ROM_OFF + 3:     m = 8'hFF;
      default:         m = (a >= BASE_LO && a < BASE_HI) ? 8'hFF : 8'h00;
    endcase
    return m;
  endfunction

  // bytes that reset forces to zero after the image load
  function automatic logic zero_on_reset(input int a);
    return (a >= 20 && a < 24) || (a >= 28 && a < BASE_HI) ||
           (a >= ROM_OFF && a < ROM_OFF + 4);
  endfunction

  // offsets whose writes must be word aligned
  function automatic logic word_only(input int a);
    return (a >= BASE_LO && a < BASE_HI) || (a >= ROM_OFF && a < ROM_OFF + 4);
  endfunction

endpackage

// File: rtl/cfgs_req_check.sv
module cfgs_req_check
  import cfgs_pkg::*;
#(
  parameter int SPACE_BYTES = 256,
  parameter int AW          = 8,
  parameter int LEN_W       = 3,
  parameter int LANES       = 4
) (
  input  logic             write,
  input  logic [AW-1:0]    offset,
  input  logic [LEN_W-1:0] len,
  output logic             err
);

  logic [AW:0] end_pos;
  logic bad_len, bad_range, bad_cmd, bad_align;

  always_comb begin
    end_pos   = {1'b0, offset} + (AW+1)'(len);
    bad_len   = (len == '0) || (len > LEN_W'(LANES));
    bad_range = end_pos > (AW+1)'(SPACE_BYTES);
    bad_cmd   = write && (offset == AW'(CMD_OFF)) && (len > LEN_W'(2));
    bad_align = write && word_only(int'(offset)) && (offset[1:0] != 2'b00);
    err       = bad_len || bad_range || bad_cmd || bad_align;
  end

endmodule

// File: rtl/cfgs_lane_merge.sv
module cfgs_lane_merge
  import cfgs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [7:0]    old_b,
  input  logic [7:0]    din,
  output logic [7:0]    new_b
);

  logic [7:0] m;
  int a;

  always_comb begin
    a = int'(addr);
    m = wr_mask(a);
    if (a >= HDR_BYTES) begin
      new_b = din;
    end else if (a == STAT_HI_OFF) begin
      new_b = old_b & ~(din & m);
    end else begin
      new_b = (old_b & ~m) | (din & m);
    end
  end

endmodule

// File: rtl/cfgs_store.sv
module cfgs_store
  import cfgs_pkg::*;
#(
  parameter int         SPACE_BYTES = 256,
  parameter int         AW          = 8,
  parameter int         LANES       = 4,
  parameter logic [7:0] IMAGE_KEY   = 8'h5A
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          lane_we,
  input  logic [LANES-1:0][AW-1:0]  lane_addr,
  input  logic [LANES-1:0][7:0]     lane_wdata,
  input  logic                      rom_zero,
  output logic [LANES-1:0][7:0]     lane_rdata,
  output logic [7:0]                cmd_byte
);

  logic [7:0] mem [SPACE_BYTES];

  function automatic logic [7:0] boot_byte(input int a);
    logic [7:0] b;
    b = 8'(a) ^ IMAGE_KEY;
    if (a == CMD_OFF) b = b & ~CMD_QUIET;
    if (zero_on_reset(a)) b = 8'h00;
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SPACE_BYTES; k++) mem[k] <= boot_byte(k);
    end else if (rom_zero) begin
      for (int j = 0; j < 4; j++) mem[ROM_OFF + j] <= 8'h00;
    end else begin
      for (int i = 0; i < LANES; i++)
        if (lane_we[i]) mem[lane_addr[i]] <= lane_wdata[i];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign lane_rdata[g] = mem[lane_addr[g]];
  end

  assign cmd_byte = mem[CMD_OFF];

  logic [7:0]  stat_lo, stat_hi;
  logic [31:0] rom_word;
  assign stat_lo  = mem[STAT_LO_OFF];
  assign stat_hi  = mem[STAT_HI_OFF];
  assign rom_word = {mem[ROM_OFF+3], mem[ROM_OFF+2], mem[ROM_OFF+1], mem[ROM_OFF]};

  // R3: low status byte has no writable bit
  p_ro_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(stat_lo));
  // R4: upper status bits never go from 0 to 1 outside reset
  p_w1c_only_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_hi & ~$past(stat_hi)) == 8'h00));
  // R6: sizing the ROM register leaves it at zero
  p_rom_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_zero |=> (rom_word == 32'h0));
  // R1: no write strobe keeps the command byte unchanged
  p_idle_keeps_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !(|lane_we) && !rom_zero) |=> $stable(cmd_byte));

endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
  import cfgs_pkg::*;
#(
  parameter int         SPACE_BYTES = 256,
  parameter int         LANES       = 4,
  parameter logic [7:0] IMAGE_KEY   = 8'h5A,
  localparam int        AW          = $clog2(SPACE_BYTES),
  localparam int        LEN_W       = $clog2(LANES) + 1,
  localparam int        DW          = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_err,
  output logic             mem_evt,
  output logic             mem_on
);

  logic accept, req_err, wr_ok, rom_zero;
  logic [LANES-1:0]          lane_act, lane_we;
  logic [LANES-1:0][AW-1:0]  lane_addr;
  logic [LANES-1:0][7:0]     lane_old, lane_new;
  logic [DW-1:0]             rd_word;
  logic [7:0]                cmd_byte;
  logic                      mem_prev;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  cfgs_req_check #(
    .SPACE_BYTES(SPACE_BYTES), .AW(AW), .LEN_W(LEN_W), .LANES(LANES)
  ) u_check (
    .write (req_write),
    .offset(req_offset),
    .len   (req_len),
    .err   (req_err)
  );

  assign wr_ok    = accept && req_write && !req_err;
  assign rom_zero = wr_ok && (req_offset == AW'(ROM_OFF)) &&
                    (req_len == LEN_W'(4)) && (&req_wdata[DW-1:ROM_LSB]);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = req_offset + AW'(g);
    assign lane_act[g]  = LEN_W'(g) < req_len;
    assign lane_we[g]   = wr_ok && lane_act[g] && !rom_zero;
    assign rd_word[g*8 +: 8] = lane_act[g] ? lane_old[g] : 8'h00;

    cfgs_lane_merge #(.AW(AW)) u_merge (
      .addr (lane_addr[g]),
      .old_b(lane_old[g]),
      .din  (req_wdata[g*8 +: 8]),
      .new_b(lane_new[g])
    );
  end

  cfgs_store #(
    .SPACE_BYTES(SPACE_BYTES), .AW(AW), .LANES(LANES), .IMAGE_KEY(IMAGE_KEY)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .lane_wdata(lane_new),
    .rom_zero  (rom_zero),
    .lane_rdata(lane_old),
    .cmd_byte  (cmd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= req_err;
      rsp_rdata <= (req_err || req_write) ? '0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mem_prev <= 1'b0;
    else        mem_prev <= cmd_byte[MEM_EN_BIT];
  end

  assign mem_on  = cmd_byte[MEM_EN_BIT];
  assign mem_evt = rst_n && (mem_on != mem_prev);

  // R10: a stalled response holds its contents
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  // R9: an event follows only an accepted good write
  p_evt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_evt |-> $past(accept && req_write && !req_err));
  // R9: the event is one cycle wide
  p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_evt |=> !mem_evt || $past(wr_ok));
  // R1: rejected requests answer with zero data
  p_err_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_err) |=> (rsp_err && rsp_rdata == '0));

endmodule

// File: tb/tb_cfgs_regfile.sv
module tb_cfgs_regfile;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_offset = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, mem_evt, mem_on;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgs_regfile dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mem_evt(mem_evt), .mem_on(mem_on)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8 image as the requirement states it
  task automatic model_reset();
    for (int k = 0; k < 256; k++) begin
      model[k] = 8'(k) ^ 8'h5A;
      if (k == 4) model[k] = model[k] & 8'hF8;
      if ((k >= 8'h14 && k <= 8'h17) || (k >= 8'h1C && k <= 8'h27) ||
          (k >= 8'h30 && k <= 8'h33)) model[k] = 8'h00;
    end
  endtask

  function automatic logic [7:0] mask_of(input int a);
    if (a == 4 || a == 8'h0C || a == 8'h3C || (a >= 8'h10 && a <= 8'h27)) return 8'hFF;
    if (a == 5) return 8'h07;
    if (a == 7) return 8'hF9;
    if (a == 8'h30) return 8'h01;
    if (a == 8'h31) return 8'hF8;
    if (a == 8'h32 || a == 8'h33) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic bit exp_error(input bit wr, input int off, input int len);
    bit e;
    e = (len == 0) || (len > 4) || (off + len > 256);
    if (wr && off == 4 && len > 2) e = 1;
    if (wr && (((off >= 8'h10) && (off <= 8'h27)) || ((off >= 8'h30) && (off <= 8'h33)))
        && (off % 4 != 0)) e = 1;
    return e;
  endfunction

  task automatic xfer(input bit wr, input int off, input int len,
                      input logic [31:0] d, input string req);
    bit e;
    logic [31:0] exp_rd;
    logic old_on, new_on;
    e = exp_error(wr, off, len);
    exp_rd = '0;
    if (!e && !wr)
      for (int i = 0; i < len; i++) exp_rd[i*8 +: 8] = model[off + i];
    old_on = model[4][1];
    @(negedge clk);
    req_valid = 1; req_write = wr; req_offset = 8'(off); req_len = 3'(len); req_wdata = d;
    @(posedge clk);
    if (!e && wr) begin
      if (off == 8'h30 && len == 4 && (&d[31:11])) begin
        for (int j = 0; j < 4; j++) model[8'h30 + j] = 8'h00;
      end else begin
        for (int i = 0; i < len; i++) begin
          int a;
          logic [7:0] m, db;
          a = off + i; db = d[i*8 +: 8]; m = mask_of(a);
          if (a >= 64)      model[a] = db;
          else if (a == 7)  model[a] = model[a] & ~(db & m);
          else              model[a] = (model[a] & ~m) | (db & m);
        end
      end
    end
    new_on = model[4][1];
    @(negedge clk);
    req_valid = 0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " rsp_err"}, 32'(rsp_err), 32'(e));
    chk({req, " rsp_rdata"}, rsp_rdata, exp_rd);
    chk({req, " R9 mem_evt"}, 32'(mem_evt), 32'(old_on != new_on));
  endtask

  // R9: outside response cycles no event; mem_on tracks the model every clock
  always @(negedge clk) if (rst_n && !done) begin
    if (!rsp_valid) chk("R9 idle mem_evt", 32'(mem_evt), 32'd0);
    chk("R9 mem_on", 32'(mem_on), 32'(model[4][1]));
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R8 reset image
    xfer(0, 0, 4, 0, "R8 id bytes");
    xfer(0, 4, 4, 0, "R8 cmd quiet");
    xfer(0, 8'h14, 4, 0, "R8 base1 zero");
    xfer(0, 8'h18, 4, 0, "R8 base2 kept");
    xfer(0, 8'h30, 4, 0, "R8 rom zero");
    // R2 lane placement
    xfer(0, 8'h41, 1, 0, "R2 single lane");
    xfer(0, 8'h42, 3, 0, "R2 three lanes");
    // R3 masked merges, R9 memory-enable rise
    xfer(1, 4, 2, 32'h0000FFFF, "R3 R9 cmd write");
    xfer(0, 4, 2, 0, "R3 cmd readback");
    xfer(1, 8'h08, 4, 32'hFFFFFFFF, "R3 read-only bytes");
    xfer(0, 8'h08, 4, 0, "R3 read-only kept");
    xfer(1, 8'h10, 4, 32'h12345678, "R3 base0 write");
    xfer(0, 8'h10, 4, 0, "R3 base0 readback");
    xfer(1, 8'h3C, 1, 32'h000000A7, "R3 irq line");
    xfer(1, 8'h3D, 1, 32'h000000FF, "R3 irq pin ro");
    xfer(0, 8'h3C, 2, 0, "R3 irq readback");
    // R4 write-one-to-clear
    xfer(1, 6, 2, 32'h0000FFFF, "R4 status ones");
    xfer(0, 6, 2, 0, "R4 status readback");
    // R5 unmasked upper space
    xfer(1, 8'h80, 4, 32'hDEADBEEF, "R5 upper write");
    xfer(0, 8'h80, 4, 0, "R5 upper readback");
    xfer(1, 8'hFC, 4, 32'h01020304, "R5 last word");
    xfer(0, 8'hFC, 4, 0, "R5 last readback");
    // R6 ROM sizing
    xfer(1, 8'h30, 4, 32'h12345678, "R6 rom masked");
    xfer(0, 8'h30, 4, 0, "R6 rom readback");
    xfer(1, 8'h30, 4, 32'hFFFFF7FF, "R6 near miss");
    xfer(0, 8'h30, 4, 0, "R6 near miss readback");
    xfer(1, 8'h30, 4, 32'hFFFFF800, "R6 all ones");
    xfer(0, 8'h30, 4, 0, "R6 zeroed");
    // R1 and R7 rejections
    xfer(0, 0, 0, 0, "R1 zero length");
    xfer(1, 8'h40, 5, 32'hFFFFFFFF, "R1 long write");
    xfer(1, 8'hFE, 4, 32'hFFFFFFFF, "R1 past end");
    xfer(0, 8'hFD, 4, 0, "R1 read past end");
    xfer(0, 8'hFC, 4, 0, "R1 no change");
    xfer(1, 4, 4, 32'h00000000, "R7 cmd too long");
    xfer(1, 8'h11, 1, 32'h000000FF, "R7 base unaligned");
    xfer(1, 8'h31, 1, 32'h000000FF, "R7 rom unaligned");
    xfer(0, 8'h10, 4, 0, "R7 base unchanged");
    xfer(0, 5, 2, 0, "R7 unaligned read ok");
    // R9 memory-enable fall
    xfer(1, 4, 1, 32'h00000000, "R9 cmd clear");
    xfer(1, 4, 1, 32'h000000FD, "R9 no bit1 change");
    // R10 back-pressure
    begin
      logic [31:0] held;
      @(negedge clk);
      rsp_ready = 0;
      req_valid = 1; req_write = 0; req_offset = 8'h80; req_len = 3'd4;
      @(posedge clk);
      @(negedge clk);
      req_write = 1; req_wdata = 32'h0; req_offset = 8'h80;
      held = rsp_rdata;
      chk("R10 first rsp", rsp_rdata, {model[8'h83], model[8'h82], model[8'h81], model[8'h80]});
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk("R10 req_ready low", 32'(req_ready), 32'd0);
        chk("R10 rsp held", rsp_rdata, held);
        chk("R10 rsp_valid held", 32'(rsp_valid), 32'd1);
      end
      req_valid = 0;
      rsp_ready = 1;
      @(negedge clk);
      chk("R10 drained", 32'(rsp_valid), 32'd0);
    end
    xfer(0, 8'h80, 4, 0, "R10 offered write not done");
    // R8 reset mid-run
    @(negedge clk) rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    xfer(0, 4, 4, 0, "R8 cmd after reset");
    xfer(0, 8'h1C, 4, 0, "R8 base3 after reset");
    xfer(0, 8'h80, 4, 0, "R8 upper after reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule